// File: doc/BRIEF.md
# Register Bank with SEC-DED Protection and Upset Injection

This block holds a small bank of data registers. Each register is kept as a codeword: the data, a Hamming check field and one parity bit over the whole word. An error in any one bit can be corrected, and an error in any two bits can be detected. A synchronous write encodes the incoming data and stores the full codeword. A combinational read port decodes the selected register. It returns the data, corrected when it can be, together with a two-bit status.

A separate upset port models a radiation hit. Each rising edge of the upset strobe inverts one chosen bit of one chosen register. The strobe does not use the functional clock, and it bypasses the encoder, so the check bits stay as they were. The damage stays hidden until that register is read. Correction happens only on the read path and is never written back. Flips therefore build up in a register until the next normal write to it. A fault campaign can use this to test how a design behaves when several upsets land in one word before it is read.

Top module: `secded_regbank`

## Requirements
- R1: A write stores wr_data into register wr_addr on the rising clock edge. From the next cycle, a read of that register returns the same data with rd_status 2'b00, provided no upset has hit that register.
- R2: While rst_n is low, every register is cleared to the all-zero codeword. After reset, every read returns data 0 with status 2'b00.
- R3: One upset in a data position of a register gives status 2'b01 on a read of that register, and rd_data returns the original data.
- R4: One upset in a check position (index 0 or a power of two) gives status 2'b01, and rd_data is unchanged.
- R5: Two upsets in different positions of one register, with no write in between, give status 2'b10.
- R6: An upset does not re-encode the word. It stays latent across any number of clock cycles and leaves all other registers unaffected.
- R7: An upset whose bit index is equal to or greater than the codeword width (22 by default) has no effect.
- R8: A normal write to a register clears all upsets gathered in that register.
- R9: rd_status takes only the values 2'b00 (clean), 2'b01 (corrected) and 2'b10 (uncorrectable). It never takes 2'b11.
- R10: An upset takes effect on the rising edge of upset_en, without any clock edge. The read port shows the change before the next clock edge.
- R11: Codeword layout: index 0 holds the parity of the whole word. Indices that are powers of two hold check bits. The remaining indices hold data bits 0 and up, in ascending order, so index 3 holds data bit 0 and index 5 holds data bit 1. When the status is 2'b10, rd_data shows the stored data without correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(NREG) | Register to write |
| wr_data | input | DW | Data to encode and store |
| rd_addr | input | $clog2(NREG) | Register to decode |
| rd_data | output | DW | Decoded data |
| rd_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| upset_en | input | 1 | Rising edge inverts one stored bit |
| upset_reg | input | $clog2(NREG) | Register targeted by the upset |
| upset_bit | input | $clog2(CW) | Codeword index to invert |

## Verification
The hardest state to reach is a register that holds two latent flips, or a flip placed exactly on a check bit. Reaching it needs upset strobes timed between clock edges, with no write to the targeted register in between. The bench pulses upset_en in mid-cycle and moves the read address over other registers while the damage waits. It then reads the damaged register and compares the result with a model that knows only each register's written value and a set of flipped positions. One directed pair of flips at indices 3 and 5 exposes the bit layout through the uncorrected data.

// File: rtl/secded_regbank.sv
module secded_regbank #(
  parameter int NREG = 8,
  parameter int DW   = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(NREG)-1:0]         wr_addr,
  input  logic [DW-1:0]                   wr_data,
  input  logic [$clog2(NREG)-1:0]         rd_addr,
  output logic [DW-1:0]                   rd_data,
  output logic [1:0]                      rd_status,
  input  logic                            upset_en,
  input  logic [$clog2(NREG)-1:0]         upset_reg,
  input  logic [$clog2(DW+$clog2(DW)+3)-1:0] upset_bit
);
  function automatic int check_bits(int d);
    int p = 1;
    while ((1 << p) < d + p + 1) p++;
    return p;
  endfunction

  localparam int PB = check_bits(DW);
  localparam int CW = DW + PB + 1;

  function automatic logic [CW-1:0] encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    for (int i = 0; i < PB; i++)
      for (int p = 1; p < CW; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) c[1 << i] = c[1 << i] ^ c[p];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  logic [CW-1:0] code_q [NREG];
  logic [CW-1:0] flip_a [NREG];
  logic [CW-1:0] flip_w [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        code_q[r] <= '0;
        flip_w[r] <= '0;
      end
    end else if (wr_en) begin
      code_q[wr_addr] <= encode(wr_data);
      flip_w[wr_addr] <= flip_a[wr_addr];
    end

  always_ff @(posedge upset_en or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) flip_a[r] <= '0;
    end else if (int'(upset_bit) < CW) begin
      flip_a[upset_reg][upset_bit] <= ~flip_a[upset_reg][upset_bit];
    end

  logic [CW-1:0] word;
  logic [CW-1:0] fixed;
  logic [PB-1:0] syn;
  logic          ovr;

  assign word = code_q[rd_addr] ^ flip_a[rd_addr] ^ flip_w[rd_addr];
  assign ovr  = ^word;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW; p++)
      if (word[p]) syn = syn ^ PB'(p);
  end

  always_comb begin
    fixed = word;
    rd_status = 2'b00;
    if (ovr) begin
      if (int'(syn) < CW) begin
        fixed[syn] = ~word[syn];
        rd_status = 2'b01;
      end else begin
        rd_status = 2'b10;
      end
    end else if (syn != '0) begin
      rd_status = 2'b10;
    end
  end

  always_comb begin
    int k;
    k = 0;
    rd_data = '0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        rd_data[k] = (rd_status == 2'b10) ? word[p] : fixed[p];
        k++;
      end
  end
endmodule

module secded_regbank_chk #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int CW   = 22
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_addr,
  input logic [DW-1:0]           wr_data,
  input logic [$clog2(NREG)-1:0] rd_addr,
  input logic [DW-1:0]           rd_data,
  input logic [1:0]              rd_status,
  input logic                    upset_en,
  input logic [$clog2(NREG)-1:0] upset_reg,
  input logic [$clog2(CW)-1:0]   upset_bit
);
  logic [31:0] hits;

  always_ff @(posedge upset_en or negedge rst_n)
    if (!rst_n) hits <= '0;
    else        hits <= hits + 32'd1;

  // R9
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status != 2'b11);

  // R1
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_addr) == rd_addr && $stable(rd_addr) && $stable(hits))
      |-> (rd_status == 2'b00 && rd_data == $past(wr_data)));

  // R2
  clean_until_upset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == 32'd0) |-> (rd_status == 2'b00));

  // R6
  hold_latent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && $stable(hits) && !$past(wr_en))
      |-> ($stable(rd_status) && $stable(rd_data)));
endmodule

bind secded_regbank secded_regbank_chk #(.NREG(NREG), .DW(DW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .rd_status(rd_status),
  .upset_en(upset_en), .upset_reg(upset_reg), .upset_bit(upset_bit)
);

// File: tb/secded_regbank_test.sv
module secded_regbank_test;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int CW   = 22;
  localparam int AW   = $clog2(NREG);
  localparam int BW   = $clog2(CW);

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [1:0]    rd_status;
  logic          upset_en = 0;
  logic [AW-1:0] upset_reg = '0;
  logic [BW-1:0] upset_bit = '0;

  secded_regbank #(.NREG(NREG), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_status(rd_status),
    .upset_en(upset_en), .upset_reg(upset_reg), .upset_bit(upset_bit)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] m_data [NREG];
  logic [CW-1:0] m_flip [NREG];

  function automatic int data_index(int p);
    int n = 0;
    for (int q = 1; q <= p; q++) if ((q & (q - 1)) == 0) n++;
    return p - n - 1;
  endfunction

  function automatic bit is_check_pos(int p);
    return p == 0 || (p & (p - 1)) == 0;
  endfunction

  task automatic expect_read(string tag, logic [1:0] es, logic [DW-1:0] ed, bit cmp_data);
    checks++;
    if (rd_status !== es || (cmp_data && rd_data !== ed)) begin
      failures++;
      $display("FAIL %s reg=%0d status=%b data=%h expected status=%b data=%h",
               tag, rd_addr, rd_status, rd_data, es, ed);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      int n;
      logic [DW-1:0] raw;
      n = $countones(m_flip[rd_addr]);
      raw = m_data[rd_addr];
      for (int p = 0; p < CW; p++)
        if (m_flip[rd_addr][p] && !is_check_pos(p)) raw[data_index(p)] = ~raw[data_index(p)];
      if (n == 0) expect_read("R1", 2'b00, m_data[rd_addr], 1);
      else if (n == 1) begin
        int pos = 0;
        for (int p = 0; p < CW; p++) if (m_flip[rd_addr][p]) pos = p;
        expect_read(is_check_pos(pos) ? "R4" : "R3", 2'b01, m_data[rd_addr], 1);
      end else if (n == 2) expect_read("R5", 2'b10, raw, 1);
      checks++;
      if (rd_status === 2'b11) begin
        failures++;
        $display("FAIL R9 status=%b expected one of 00/01/10", rd_status);
      end
    end
  end

  task automatic do_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk);
    m_data[a] = d;
    m_flip[a] = '0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_upset(int a, int b);
    @(negedge clk);
    upset_reg = AW'(a); upset_bit = BW'(b);
    #3 upset_en = 1;
    if (b < CW) m_flip[a][b] = ~m_flip[a][b];
    #3 upset_en = 0;
  endtask

  task automatic set_read(int a);
    @(negedge clk);
    rd_addr = AW'(a);
    #1;
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) begin m_data[r] = '0; m_flip[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int r = 0; r < NREG; r++) begin
      set_read(r);
      expect_read("R2", 2'b00, '0, 1);
    end

    for (int r = 0; r < NREG; r++) do_write(r, DW'(16'h1357 * (r + 1) ^ 16'hA5C3));
    for (int r = 0; r < NREG; r++) set_read(r);

    do_upset(2, 6);
    set_read(3);
    expect_read("R6", 2'b00, m_data[3], 1);
    repeat (5) @(posedge clk);
    set_read(2);
    expect_read("R3", 2'b01, m_data[2], 1);
    repeat (3) @(posedge clk);
    expect_read("R6", 2'b01, m_data[2], 1);

    do_upset(2, 13);
    set_read(2);
    expect_read("R5", 2'b10, '0, 0);

    do_write(2, 16'h0F0F);
    set_read(2);
    expect_read("R8", 2'b00, 16'h0F0F, 1);

    do_upset(4, 0);
    set_read(4);
    expect_read("R4", 2'b01, m_data[4], 1);
    do_write(4, 16'hBEEF);
    do_upset(4, 8);
    set_read(4);
    expect_read("R4", 2'b01, 16'hBEEF, 1);

    set_read(5);
    do_upset(5, 25);
    #1 expect_read("R7", 2'b00, m_data[5], 1);
    do_upset(5, 31);
    #1 expect_read("R7", 2'b00, m_data[5], 1);

    set_read(7);
    do_upset(7, 11);
    #1 expect_read("R10", 2'b01, m_data[7], 1);

    do_write(6, 16'h8000);
    set_read(6);
    do_upset(6, 3);
    do_upset(6, 5);
    #1 expect_read("R11", 2'b10, 16'h8003, 1);

    do_write(1, 16'hFFFF);
    set_read(1);
    do_upset(1, 21);
    do_upset(1, 1);
    #1 expect_read("R5", 2'b10, 16'h7FFF, 1);

    for (int r = 0; r < NREG; r++) do_write(r, DW'(r * 16'h1111));
    for (int r = 0; r < NREG; r++) begin
      do_upset(r, (r * 3 + 2) % CW);
      set_read(r);
      @(posedge clk);
    end

    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule